// File: doc/BRIEF.md
# Hub Configuration Loader

This block runs once after reset inside a fixed-function USB hub controller and settles three configuration values: the 16-bit vendor ID, the 16-bit product ID and the ganged-power flag. No firmware is involved. The block finishes on its own, then holds its results until the next reset.

A source-select strap is sampled on the first clock edge after reset. With the strap high, the IDs take built-in parameter defaults. A shared pin then acts as a plain input that sets the ganged flag, and the serial interface stays idle. With the strap low, the same pin becomes the bidirectional data line of a three-wire serial EEPROM (chip select, clock, data). The block reads three words from addresses 0, 1 and 2. Word 0 carries the ganged flag in bit 0, word 1 the vendor ID and word 2 the product ID. A one-cycle done strobe marks the moment the outputs become valid. Until then, downstream logic must ignore the outputs.

Top module: `hubcfg_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `vid`=DEF_VID, `pid`=DEF_PID, `ganged`=0 and `done`=0, with `ee_cs`, `ee_sk` and `ee_dio_oe` all 0.
- R2: `strap_ext` is sampled only at the first clock edge with `rst` low. Later changes to it have no effect until the next reset.
- R3: With the strap sampled high, `done` is 1 for exactly the cycle after that first edge, `vid`/`pid` keep their defaults, and `ee_cs`, `ee_sk` and `ee_dio_oe` stay 0.
- R4: With the strap sampled high, `ganged` equals the value `ee_dio_i` had at the previous clock edge (one register of latency), and it keeps tracking the pin.
- R5: With the strap sampled low, each serial clock period lasts SK_DIV core cycles: `ee_sk` is low for the first SK_DIV/2 cycles and high for the rest. Each word keeps `ee_cs` high for 26 periods, and `ee_sk` is never high while `ee_cs` is low.
- R6: Each word begins with a 9-bit read command driven MSB first on `ee_dio_o` with `ee_dio_oe`=1: start bit 1, opcode bits 1 then 0, then the 6-bit word address. The bit changes at the start of each period (the falling edge of the serial clock). The data line is released (`ee_dio_oe`=0) at the 9th rising serial edge.
- R7: Input data is sampled at rising serial edges. The 10th rising edge of a word carries the EEPROM's dummy zero and is discarded. Rising edges 11 to 26 deliver data bits 15 down to 0.
- R8: Words are read from addresses 0, 1, 2 in that order. `ganged` takes bit 0 of word 0 and ignores its other bits. `vid` takes word 1 and `pid` takes word 2.
- R9: Between words, `ee_cs` is low for exactly SK_DIV core cycles.
- R10: In EEPROM mode, `done` is 1 for exactly one cycle, 80·SK_DIV cycles after the first post-reset edge. `vid`, `pid` and `ganged` keep their defaults until that cycle and stay stable afterwards.
- R11: A reset during a transfer aborts it. The next release restarts from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_ext | input | 1 | Source select: 1 = built-in defaults, 0 = serial EEPROM |
| ee_dio_i | input | 1 | Shared pin input: ganged strap or EEPROM data in |
| ee_dio_o | output | 1 | EEPROM data out (command bits) |
| ee_dio_oe | output | 1 | Output enable for the shared pin |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| vid | output | DATA_W | Vendor ID |
| pid | output | DATA_W | Product ID |
| ganged | output | 1 | Ganged power-switching flag |
| done | output | 1 | One-cycle strobe marking valid configuration |

## Verification
Every output is a register. All results are therefore due one cycle after the edge that decides them.

| Result | When it is due |
|---|---|
| Fixed-mode `done` | Cycle after the first edge with reset low |
| Fixed-mode `ganged` | One edge behind the pin |
| Serial clock edges | SK_DIV/2 and SK_DIV cycles into each period |
| Next word's chip select | 27·SK_DIV cycles after the previous word's start |
| EEPROM-mode `done` | Exactly 80·SK_DIV cycles after that first edge |

The bench's reference model advances an edge counter on each rising clock edge and derives the expected value of every output from it. All outputs are compared on the following falling edge, so each comparison falls in the cycle where the result has already settled. A model of the EEPROM answers on the serial clock. It also checks the start bit, opcode and address of each command as the command arrives.

// File: rtl/hubcfg_pkg.sv
package hubcfg_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_XFER,
    ST_GAP,
    ST_FIXED,
    ST_DONE
  } ld_state_t;

  localparam logic [2:0] READ_HDR = 3'b110; // start bit, then read opcode
  localparam int unsigned NWORD = 3;
endpackage

// File: rtl/hubcfg_skgen.sv
module hubcfg_skgen #(
  parameter int unsigned SK_DIV = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sk,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = (SK_DIV > 1) ? $clog2(SK_DIV) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(SK_DIV / 2 - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(SK_DIV - 1);

  logic [CW-1:0] div_q;
  logic          sk_q;

  assign rise = run && (div_q == RISE_AT);
  assign fall = run && (div_q == FALL_AT);
  assign sk   = sk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      sk_q  <= 1'b0;
    end else begin
      div_q <= fall ? '0 : div_q + 1'b1;
      if (rise)      sk_q <= 1'b1;
      else if (fall) sk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hubcfg_shift.sv
module hubcfg_shift
  import hubcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic              dout,
  output logic              oe,
  output logic [DATA_W-1:0] data,
  output logic              word_done
);
  localparam int unsigned CMD_W = ADDR_W + 3;
  localparam int unsigned TOTAL = CMD_W + 1 + DATA_W;
  localparam int unsigned EW    = $clog2(TOTAL + 1);

  logic [CMD_W-1:0]  cmd_q;
  logic [EW-1:0]     edges_q;
  logic              oe_q;
  logic [DATA_W-1:0] data_q;

  assign dout      = cmd_q[CMD_W-1];
  assign oe        = oe_q;
  assign data      = data_q;
  assign word_done = fall && (edges_q == EW'(TOTAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      edges_q <= '0;
      oe_q    <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      cmd_q   <= {READ_HDR, addr};
      edges_q <= '0;
      oe_q    <= 1'b1;
    end else if (rise) begin
      edges_q <= edges_q + 1'b1;
      // last command bit goes out on this edge: hand the line to the memory
      if (edges_q == EW'(CMD_W - 1)) oe_q <= 1'b0;
      // the edge right after the command carries the dummy zero: skip it
      if (edges_q >= EW'(CMD_W + 1)) data_q <= {data_q[DATA_W-2:0], din};
    end else if (fall) begin
      cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/hubcfg_ctrl.sv
module hubcfg_ctrl
  import hubcfg_pkg::*;
#(
  parameter int unsigned       SK_DIV  = 48,
  parameter int unsigned       ADDR_W  = 6,
  parameter int unsigned       DATA_W  = 16,
  parameter logic [DATA_W-1:0] DEF_VID = 16'hC0DE,
  parameter logic [DATA_W-1:0] DEF_PID = 16'h0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic              pin,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word_data,
  output logic              run,
  output logic              load,
  output logic [ADDR_W-1:0] addr,
  output logic              cs,
  output logic [DATA_W-1:0] vid,
  output logic [DATA_W-1:0] pid,
  output logic              ganged,
  output logic              done
);
  localparam int unsigned   GW      = (SK_DIV > 1) ? $clog2(SK_DIV) : 1;
  localparam logic [GW-1:0] GAP_END = GW'(SK_DIV - 1);
  localparam logic [1:0]    LAST_W  = 2'(NWORD - 1);

  ld_state_t         state_q;
  logic [1:0]        widx_q;
  logic [GW-1:0]     gap_q;
  logic              sh_gang_q;
  logic [DATA_W-1:0] sh_vid_q;

  assign run  = (state_q == ST_XFER);
  assign load = ((state_q == ST_START) && !strap) ||
                ((state_q == ST_GAP) && (gap_q == GAP_END));
  assign addr = ADDR_W'(widx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_START;
      widx_q    <= '0;
      gap_q     <= '0;
      sh_gang_q <= 1'b0;
      sh_vid_q  <= DEF_VID;
      cs        <= 1'b0;
      vid       <= DEF_VID;
      pid       <= DEF_PID;
      ganged    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_START: begin
          if (strap) begin
            state_q <= ST_FIXED;
            ganged  <= pin;
            done    <= 1'b1;
          end else begin
            state_q <= ST_XFER;
            cs      <= 1'b1;
          end
        end
        ST_FIXED: ganged <= pin;
        ST_XFER: begin
          if (word_done) begin
            cs     <= 1'b0;
            gap_q  <= '0;
            widx_q <= widx_q + 1'b1;
            case (widx_q)
              2'd0:    sh_gang_q <= word_data[0];
              2'd1:    sh_vid_q  <= word_data;
              default: begin
                vid    <= sh_vid_q;
                pid    <= word_data;
                ganged <= sh_gang_q;
                done   <= 1'b1;
              end
            endcase
            state_q <= (widx_q == LAST_W) ? ST_DONE : ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_END) begin
            state_q <= ST_XFER;
            cs      <= 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hubcfg_loader.sv
module hubcfg_loader #(
  parameter int unsigned       SK_DIV  = 48,
  parameter int unsigned       ADDR_W  = 6,
  parameter int unsigned       DATA_W  = 16,
  parameter logic [DATA_W-1:0] DEF_VID = 16'hC0DE,
  parameter logic [DATA_W-1:0] DEF_PID = 16'h0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_ext,
  input  logic              ee_dio_i,
  output logic              ee_dio_o,
  output logic              ee_dio_oe,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic [DATA_W-1:0] vid,
  output logic [DATA_W-1:0] pid,
  output logic              ganged,
  output logic              done
);
  logic              run, load, rise, fall, word_done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word_data;

  hubcfg_ctrl #(
    .SK_DIV(SK_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEF_VID(DEF_VID), .DEF_PID(DEF_PID)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strap(strap_ext), .pin(ee_dio_i),
    .word_done(word_done), .word_data(word_data),
    .run(run), .load(load), .addr(addr), .cs(ee_cs),
    .vid(vid), .pid(pid), .ganged(ganged), .done(done)
  );

  hubcfg_skgen #(.SK_DIV(SK_DIV)) u_skgen (
    .clk(clk), .rst(rst), .run(run),
    .sk(ee_sk), .rise(rise), .fall(fall)
  );

  hubcfg_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .addr(addr),
    .rise(rise), .fall(fall), .din(ee_dio_i),
    .dout(ee_dio_o), .oe(ee_dio_oe), .data(word_data), .word_done(word_done)
  );
endmodule

// File: rtl/hubcfg_loader_chk.sv
module hubcfg_loader_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_dio_oe,
  input logic [DATA_W-1:0] vid,
  input logic [DATA_W-1:0] pid
);
  // R10: the strobe never lasts two cycles
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: identifiers move only in the strobe cycle
  a_r10_ids_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(vid) && $stable(pid)));

  // R5: serial clock only runs inside a chip-select frame
  a_r5_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);

  // R5: a frame ends with the serial clock low
  a_r5_cs_ends_sk_low: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs) |-> !ee_sk);

  // R6: the data line is driven only inside a frame
  a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    ee_dio_oe |-> ee_cs);
endmodule

bind hubcfg_loader hubcfg_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .ee_cs(ee_cs), .ee_sk(ee_sk),
  .ee_dio_oe(ee_dio_oe), .vid(vid), .pid(pid)
);

// File: tb/hubcfg_loader_test.sv
`timescale 1ns/1ps
module hubcfg_loader_test;
  localparam int D    = 8;
  localparam int HALF = D / 2;
  localparam int WLEN = 27 * D;
  localparam logic [15:0] DVID = 16'hC0DE;
  localparam logic [15:0] DPID = 16'h0007;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b1;
  logic gpin = 1'b0;
  logic dev_out = 1'b0;
  logic din;
  logic ee_dio_o, ee_dio_oe, ee_cs, ee_sk, ganged, done;
  logic [15:0] vid, pid;
  logic [15:0] mem [0:63];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int t = 0;
  logic mfixed = 1'b0;
  logic g_fix = 1'b0;

  always #4 clk = ~clk;

  assign din = strap ? gpin : (ee_dio_oe ? ee_dio_o : dev_out);

  hubcfg_loader #(.SK_DIV(D), .ADDR_W(6), .DATA_W(16), .DEF_VID(DVID), .DEF_PID(DPID)) uut (
    .clk(clk), .rst(rst), .strap_ext(strap), .ee_dio_i(din),
    .ee_dio_o(ee_dio_o), .ee_dio_oe(ee_dio_oe), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .vid(vid), .pid(pid), .ganged(ganged), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // EEPROM model: responds on the serial clock, checks each command (R6, R8)
  int dn = 0;
  logic [8:0] dcmd = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      dn = 0;
      dcmd = '0;
    end else begin
      dn = dn + 1;
      if (dn <= 9) dcmd = {dcmd[7:0], ee_dio_o};
      if (dn == 9) begin
        dev_out <= 1'b0;  // dummy zero (R7)
        chk("R6 start+opcode", 32'(dcmd[8:6]), 32'h6);
        chk("R8 word address", 32'(dcmd[5:0]), 32'((t - 1) / WLEN));
      end else if (dn >= 10 && dn <= 25) begin
        dev_out <= mem[dcmd[5:0]][4'(25 - dn)];
      end
    end
  end

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      finish_run();
    end
    if (rst) begin
      t = 0;
      g_fix = 1'b0;
    end else begin
      t = t + 1;
      if (t == 1) mfixed = strap;   // R2: sampled once
      if (mfixed) g_fix = din;      // R4
    end
  end

  // compare every output half a cycle later
  always @(negedge clk) begin
    logic [15:0] e_vid, e_pid;
    logic e_g, e_done, e_cs, e_sk, e_oe;
    logic [8:0] cmd;
    int k, r;
    e_vid = DVID; e_pid = DPID; e_g = 1'b0; e_done = 1'b0;
    e_cs = 1'b0; e_sk = 1'b0; e_oe = 1'b0; k = 0; r = 0; cmd = '0;
    if (t >= 1) begin
      if (mfixed) begin
        e_g = g_fix;
        e_done = (t == 1);
      end else begin
        k = (t - 1) / WLEN;
        r = (t - 1) % WLEN;
        if (t - 1 >= 80 * D) begin
          e_vid = mem[1]; e_pid = mem[2]; e_g = mem[0][0];
          e_done = (t - 1 == 80 * D);
        end else if (r < 26 * D) begin
          e_cs = 1'b1;
          e_sk = (r % D) >= HALF;
          e_oe = r < 8 * D + HALF;
        end
      end
    end
    if (t == 0) begin
      chk("R1 vid", 32'(vid), 32'(e_vid));
      chk("R1 pid", 32'(pid), 32'(e_pid));
      chk("R1 ganged", 32'(ganged), 32'(e_g));
      chk("R1 done", 32'(done), 32'(e_done));
      chk("R1 cs/sk/oe", 32'({ee_cs, ee_sk, ee_dio_oe}), 32'h0);
    end else if (mfixed) begin
      chk("R3 vid", 32'(vid), 32'(e_vid));
      chk("R3 pid", 32'(pid), 32'(e_pid));
      chk("R3 done", 32'(done), 32'(e_done));
      chk("R3 cs/sk/oe idle", 32'({ee_cs, ee_sk, ee_dio_oe}), 32'h0);
      chk("R4 ganged follows pin", 32'(ganged), 32'(e_g));
    end else begin
      chk("R10 R8 vid", 32'(vid), 32'(e_vid));
      chk("R10 R8 pid", 32'(pid), 32'(e_pid));
      chk("R10 R8 ganged", 32'(ganged), 32'(e_g));
      chk("R10 done", 32'(done), 32'(e_done));
      if (t - 1 < 80 * D && r >= 26 * D) chk("R9 gap cs", 32'(ee_cs), 32'(e_cs));
      else chk("R5 cs frame", 32'(ee_cs), 32'(e_cs));
      chk("R5 sk", 32'(ee_sk), 32'(e_sk));
      chk("R6 oe", 32'(ee_dio_oe), 32'(e_oe));
      if (e_oe) begin
        cmd = {3'b110, 6'(k)};
        chk("R6 command bit", 32'(ee_dio_o), 32'(cmd[4'(8 - r / D)]));
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run(3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0101);
    run(3);
    // fixed mode: R3, R4, then strap change ignored (R2)
    strap = 1'b1; gpin = 1'b1;
    rst = 1'b0;
    run(10);
    gpin = 1'b0;
    run(6);
    gpin = 1'b1;
    run(4);
    strap = 1'b0;
    run(40);
    chk("R2 strap ignored, cs low", 32'(ee_cs), 32'h0);
    chk("R2 strap ignored, vid default", 32'(vid), 32'(DVID));

    // EEPROM mode, ganged set (R5-R10)
    do_reset();
    strap = 1'b0;
    mem[0] = 16'h0001; mem[1] = 16'h1234; mem[2] = 16'hABCD;
    rst = 1'b0;
    run(80 * D + 20);
    chk("R8 final vid", 32'(vid), 32'h1234);

    // EEPROM mode, word 0 bit 0 clear with other bits set (R8)
    do_reset();
    mem[0] = 16'hFFFE; mem[1] = 16'h8001; mem[2] = 16'h7FFE;
    rst = 1'b0;
    run(80 * D + 20);
    chk("R8 ganged from bit 0 only", 32'(ganged), 32'h0);

    // reset in the middle of word 1, then full reload (R11)
    do_reset();
    mem[0] = 16'h0003; mem[1] = 16'h5A5A; mem[2] = 16'h0F0F;
    rst = 1'b0;
    run(30 * D);
    rst = 1'b1;
    run(1);
    chk("R11 cs dropped by reset", 32'(ee_cs), 32'h0);
    run(2);
    mem[1] = 16'hA5C3;
    rst = 1'b0;
    run(80 * D + 20);
    chk("R11 restart vid", 32'(vid), 32'hA5C3);
    chk("R11 restart pid", 32'(pid), 32'h0F0F);
    finish_run();
  end
endmodule